// File: doc/BRIEF.md
# Hop-Class Source Buffer Slot Allocator

This block hands out packet slots in a node's source buffer, which holds both locally injected packets and packets parked in transit. It avoids store-and-forward deadlock with a structured pool. The slots form two partitions. The general partition takes any packet. The reserved partition is split into one class per possible hop distance, up to the network diameter. A requester asks for a slot and supplies the number of hops the packet still has to travel. One cycle later the block either grants a slot number or refuses the request. When the packet leaves, the requester releases the slot by number.

The general partition is always tried first. Reserved classes come into play only when every general slot is taken. Reserved class c accepts a packet only if the packet has c+1 hops or fewer left. The block stores no packet data, and it does not compute the hop count.

Top module: `hop_pool_alloc`

## Requirements
- R1: While reset is applied, and after it is released, every slot is free and neither alloc_grant nor alloc_fail is asserted.
- R2: A request seen at a rising clock edge gives exactly one one-cycle pulse after that edge: either alloc_grant or alloc_fail, never both. A cycle with no request gives neither.
- R3: While the general partition has a free slot, the grant is the lowest-numbered free general slot, whatever hops_left is. General slots are numbered 0 to GEN_SLOTS-1.
- R4: When no general slot is free, reserved class c takes slot numbers GEN_SLOTS + c*CLASS_SLOTS + j, with j from 0 to CLASS_SLOTS-1. A packet with h hops left may use any class c with c+1 >= h, and a packet with 0 hops is treated like one with 1. The grant is the lowest-numbered free slot of the lowest eligible class that has one.
- R5: When no general slot and no eligible reserved slot is free, alloc_fail pulses and no slot changes state. This holds even if lower, ineligible classes have free slots.
- R6: A free_req on an occupied slot returns that slot to its own partition and class. The slot can be granted from the next request onward.
- R7: A free_req on a slot that is already free has no effect on any later grant.
- R8: When a request and a free_req arrive at the same edge, the allocation decision uses the occupancy from before that free. The slot being released cannot be granted at that edge.
- R9: A packet whose hop count exceeds NUM_CLASSES has no eligible reserved class. Once the general partition is full, such a request fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alloc_req | input | 1 | Request a slot this cycle |
| hops_left | input | HOP_W | Remaining hop count of the packet requesting a slot |
| alloc_grant | output | 1 | One-cycle pulse: alloc_slot_id holds the granted slot |
| alloc_fail | output | 1 | One-cycle pulse: the request was refused |
| alloc_slot_id | output | SLOT_W | Granted slot number |
| free_req | input | 1 | Release a slot this cycle |
| free_slot_id | input | SLOT_W | Slot number to release |

## Verification
The bench keeps its own occupancy model and replays every request against it. It targets five cases.

- **General pool not preferred.** Requests arrive while the general pool still has room. A design that skips the general pool takes reserved slots early.
- **Fallback rule wrong.** With general full, the bench fills the classes upward by hop count. A design with a wrong fallback lands a packet in an ineligible, lower class, or fails to move to a higher class.
- **Ineligible free slot.** A lower class with a free slot must still produce a refusal. Hop counts above the class count must also be refused.
- **Double release.** A slot released twice must not count as two free slots.
- **Release in the same cycle as a request.** A design that lets the release through would grant the slot being released at that same edge.

A long stretch of mixed random traffic then compares every pulse against the model.

// File: rtl/hop_pool_pkg.sv
package hop_pool_pkg;
  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/slot_freemap.sv
module slot_freemap
  import hop_pool_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int IDX_W = safe_clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_en,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             any_free,
  output logic [IDX_W-1:0] pick_idx
);
  logic [WIDTH-1:0] free_q, free_d;

  // lowest free slot
  always_comb begin
    any_free = 1'b0;
    pick_idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        any_free = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  // release only acts on an occupied slot, so it never overrides a take
  always_comb begin
    free_d = free_q;
    if (take_en) free_d[take_idx] = 1'b0;
    if (rel_en && !free_q[rel_idx]) free_d[rel_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else if (take_en || rel_en) free_q <= free_d;
  end

  // R6: a slot is only taken while it is free
  a_r6_take_only_free: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |-> free_q[take_idx]);

  // R7: releasing a free slot leaves the map unchanged
  a_r7_double_free_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && free_q[rel_idx] && !take_en) |=> $stable(free_q));
endmodule

// File: rtl/hop_class_sel.sv
module hop_class_sel
  import hop_pool_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int HOP_W = 4,
  localparam int CLS_W = safe_clog2(NUM_CLASSES)
) (
  input  logic [HOP_W-1:0]       hops,
  input  logic [NUM_CLASSES-1:0] cls_avail,
  output logic                   hit,
  output logic [CLS_W-1:0]       cls
);
  logic [NUM_CLASSES-1:0] elig;

  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      elig[c] = cls_avail[c] && ((c + 1) >= int'(hops));
    end
  end

  always_comb begin
    hit = 1'b0;
    cls = '0;
    for (int c = NUM_CLASSES - 1; c >= 0; c--) begin
      if (elig[c]) begin
        hit = 1'b1;
        cls = CLS_W'(c);
      end
    end
  end
endmodule

// File: rtl/hop_pool_alloc.sv
module hop_pool_alloc
  import hop_pool_pkg::*;
#(
  parameter int GEN_SLOTS   = 8,
  parameter int NUM_CLASSES = 4,
  parameter int CLASS_SLOTS = 2,
  parameter int HOP_W       = 4,
  localparam int TOTAL  = GEN_SLOTS + NUM_CLASSES * CLASS_SLOTS,
  localparam int SLOT_W = safe_clog2(TOTAL),
  localparam int GIDX_W = safe_clog2(GEN_SLOTS),
  localparam int SIDX_W = safe_clog2(CLASS_SLOTS),
  localparam int CLS_W  = safe_clog2(NUM_CLASSES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [HOP_W-1:0]  hops_left,
  output logic              alloc_grant,
  output logic              alloc_fail,
  output logic [SLOT_W-1:0] alloc_slot_id,
  input  logic              free_req,
  input  logic [SLOT_W-1:0] free_slot_id
);
  // reset synchronizer: assert at once, release on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // general partition
  logic              gen_any, gen_take, gen_rel;
  logic [GIDX_W-1:0] gen_pick, gen_rel_idx;

  assign gen_rel     = free_req && (int'(free_slot_id) < GEN_SLOTS);
  assign gen_rel_idx = GIDX_W'(free_slot_id);

  slot_freemap #(.WIDTH(GEN_SLOTS)) u_gen_map (
    .clk     (clk),
    .rst_n   (rst_ok),
    .take_en (gen_take),
    .take_idx(gen_pick),
    .rel_en  (gen_rel),
    .rel_idx (gen_rel_idx),
    .any_free(gen_any),
    .pick_idx(gen_pick)
  );

  // reserved partition, one map per hop class
  logic [NUM_CLASSES-1:0] cls_any, cls_take, cls_rel;
  logic [SIDX_W-1:0]      cls_pick    [NUM_CLASSES];
  logic [SIDX_W-1:0]      cls_rel_idx [NUM_CLASSES];
  logic                   sel_hit;
  logic [CLS_W-1:0]       sel_cls;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    localparam int BASE = GEN_SLOTS + c * CLASS_SLOTS;

    assign cls_rel[c] = free_req && (int'(free_slot_id) >= BASE)
                        && (int'(free_slot_id) < BASE + CLASS_SLOTS);
    assign cls_rel_idx[c] = SIDX_W'(int'(free_slot_id) - BASE);
    assign cls_take[c] = alloc_req && !gen_any && sel_hit
                         && (int'(sel_cls) == c);

    slot_freemap #(.WIDTH(CLASS_SLOTS)) u_cls_map (
      .clk     (clk),
      .rst_n   (rst_ok),
      .take_en (cls_take[c]),
      .take_idx(cls_pick[c]),
      .rel_en  (cls_rel[c]),
      .rel_idx (cls_rel_idx[c]),
      .any_free(cls_any[c]),
      .pick_idx(cls_pick[c])
    );
  end

  hop_class_sel #(.NUM_CLASSES(NUM_CLASSES), .HOP_W(HOP_W)) u_sel (
    .hops     (hops_left),
    .cls_avail(cls_any),
    .hit      (sel_hit),
    .cls      (sel_cls)
  );

  assign gen_take = alloc_req && gen_any;

  // next-state of the response registers
  logic              grant_d, fail_d;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    grant_d = 1'b0;
    fail_d  = 1'b0;
    slot_d  = alloc_slot_id;
    if (alloc_req) begin
      if (gen_any) begin
        grant_d = 1'b1;
        slot_d  = SLOT_W'(int'(gen_pick));
      end else if (sel_hit) begin
        grant_d = 1'b1;
        slot_d  = SLOT_W'(GEN_SLOTS + int'(sel_cls) * CLASS_SLOTS
                          + int'(cls_pick[sel_cls]));
      end else begin
        fail_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      alloc_grant   <= 1'b0;
      alloc_fail    <= 1'b0;
      alloc_slot_id <= '0;
    end else begin
      alloc_grant <= grant_d;
      alloc_fail  <= fail_d;
      if (grant_d) alloc_slot_id <= slot_d;
    end
  end

  // R2: never both outcomes at once
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_ok)
    !(alloc_grant && alloc_fail));

  // R2: an outcome pulse always follows a request
  a_r2_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_ok)
    (alloc_grant || alloc_fail) |-> $past(alloc_req));

  // R4: a reserved slot is only granted when the general pool was empty
  a_r4_general_first: assert property (@(posedge clk) disable iff (!rst_ok)
    (alloc_grant && (int'(alloc_slot_id) >= GEN_SLOTS)) |-> $past(!gen_any));

  // R5: a refusal implies the general pool was empty
  a_r5_fail_only_when_full: assert property (@(posedge clk) disable iff (!rst_ok)
    alloc_fail |-> $past(!gen_any));

  // R1: all free right after reset
  a_r1_reset_free: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(rst_ok) |-> (gen_any && (&cls_any)));
endmodule

// File: tb/hop_pool_alloc_tb.sv
module hop_pool_alloc_tb;
  localparam int CLK_P = 10;
  localparam int G = 8;
  localparam int K = 4;
  localparam int S = 2;
  localparam int HW = 4;
  localparam int N = G + K * S;
  localparam int SW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0;
  logic [HW-1:0] hops_left = '0;
  logic free_req = 1'b0;
  logic [SW-1:0] free_slot_id = '0;
  logic alloc_grant, alloc_fail;
  logic [SW-1:0] alloc_slot_id;

  always #(CLK_P/2) clk = ~clk;

  hop_pool_alloc #(.GEN_SLOTS(G), .NUM_CLASSES(K), .CLASS_SLOTS(S), .HOP_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .hops_left(hops_left),
    .alloc_grant(alloc_grant), .alloc_fail(alloc_fail), .alloc_slot_id(alloc_slot_id),
    .free_req(free_req), .free_slot_id(free_slot_id)
  );

  typedef struct {
    logic grant;
    logic fail;
    int   slot;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  bit   busy[N];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  function automatic void report(string tag, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endfunction

  // model: decide on old occupancy, then apply take and valid release
  task automatic step(input bit req, input int hops, input bit frq, input int fid,
                      input string tag);
    exp_t e;
    bit   rel_ok;
    @(negedge clk);
    alloc_req    = req;
    hops_left    = HW'(hops);
    free_req     = frq;
    free_slot_id = SW'(fid);
    e.grant = 0; e.fail = 0; e.slot = -1; e.tag = tag;
    rel_ok = frq && (fid < N) && busy[fid];
    if (req) begin
      for (int i = 0; i < G; i++) if (e.slot < 0 && !busy[i]) e.slot = i;
      if (e.slot < 0) begin
        for (int c = ((hops == 0) ? 0 : hops - 1); c < K; c++)
          for (int j = 0; j < S; j++)
            if (e.slot < 0 && !busy[G + c*S + j]) e.slot = G + c*S + j;
      end
      if (e.slot >= 0) begin e.grant = 1; busy[e.slot] = 1; end
      else e.fail = 1;
    end
    if (rel_ok) busy[fid] = 0;
    exp_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        report(e.tag, "grant", int'(alloc_grant), int'(e.grant));
        report(e.tag, "fail", int'(alloc_fail), int'(e.fail));
        if (e.grant && alloc_grant) report(e.tag, "slot", int'(alloc_slot_id), e.slot);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) busy[i] = 0;
    repeat (3) @(negedge clk);
    report("R1", "grant in reset", int'(alloc_grant), 0);
    report("R1", "fail in reset", int'(alloc_fail), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report("R1", "grant after reset", int'(alloc_grant), 0);
    report("R1", "fail after reset", int'(alloc_fail), 0);

    // R2: idle cycle gives no pulse
    step(0, 0, 0, 0, "R2 idle");
    // R3: general pool filled in order, hop count irrelevant
    for (int i = 0; i < G; i++) step(1, (i % 6), 0, 0, "R3 general fill");
    // R4: fallback to classes
    step(1, 2, 0, 0, "R4 hop2 class1");
    step(1, 2, 0, 0, "R4 hop2 class1 second");
    step(1, 2, 0, 0, "R4 hop2 moves up to class2");
    step(1, 1, 0, 0, "R4 hop1 class0");
    step(1, 0, 0, 0, "R4 hop0 as hop1");
    step(1, 4, 0, 0, "R4 hop4 class3");
    step(1, 4, 0, 0, "R4 hop4 class3 second");
    step(1, 4, 0, 0, "R5 hop4 all eligible full");
    step(1, 9, 0, 0, "R9 hop above classes");
    step(1, 3, 0, 0, "R4 hop3 last class2 slot");
    step(1, 1, 0, 0, "R5 everything full");
    // R6: release and reuse
    step(0, 0, 1, 3, "R6 release general");
    step(1, 4, 0, 0, "R6 reuse general");
    // R7: double release
    step(0, 0, 1, 5, "R7 release once");
    step(0, 0, 1, 5, "R7 release again");
    step(1, 1, 0, 0, "R7 take freed");
    step(1, 1, 0, 0, "R7 no second copy");
    // R8: same-edge release and request
    step(1, 1, 1, 2, "R8 release same edge");
    step(1, 1, 0, 0, "R8 released slot next");
    // R5: lower class free but ineligible
    step(0, 0, 1, 10, "R5 free class1 slot");
    step(1, 3, 0, 0, "R5 ineligible lower class");
    step(1, 2, 0, 0, "R4 eligible class1 reused");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 3);
      step(op != 0, $urandom_range(0, 6), op >= 2, $urandom_range(0, N-1),
           "R3/R4/R6 random");
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule